// File: doc/BRIEF.md
# Bus Low-Time Measurement Timer

This block measures how long a single-wire open-drain bus is held low, so that software can sort each pulse into a sync pulse, a 0 bit or a 1 bit. The bus line is brought into the timer's clock domain through a two-flop synchroniser. Its edges are detected on the synchronised copy. The whole block runs from the slow low-power clock of about 131 kHz, so the held count gives the low time in units of that clock.

A falling edge clears the counter and starts it. The next rising edge freezes it, and the frozen value stays on `low_cnt` for software to read. When the rising-edge interrupt is enabled, the rising edge also sets a sticky status flag, and that flag drives the interrupt request. Software writes 1 through `stat_clr` to clear the flag. The block only does any of this while `bus_mode` is set. With `bus_mode` low it stays idle and ignores the bus.

Top module: `lowtime_timer`

## Requirements
- R1: After reset, `low_cnt` is 0, `edge_stat` is 0 and `irq` is 0.
- R2: Bus high again is the end of a low pulse. For such a pulse with `bus_mode` = 1, `low_cnt` settles to N-1 and holds it. N is the number of rising clock edges at which `bus_in` was sampled low during the pulse.
- R3: After the rising edge of the bus, `low_cnt` stays unchanged while the bus stays high.
- R4: The counter saturates at 65535 and does not wrap, however long the bus stays low.
- R5: While `bus_mode` = 0, bus pulses are ignored. `low_cnt` keeps its previous value and `edge_stat` is not set.
- R6: With `bus_mode` = 1 and `rise_ie` = 1, the bus rising edge sets `edge_stat`. `irq` is asserted whenever `edge_stat` is 1.
- R7: With `rise_ie` = 0, a bus rising edge does not set `edge_stat`. The pulse is still measured.
- R8: A one-cycle pulse on `stat_clr` clears `edge_stat` and `irq`.
- R9: If `stat_clr` is pulsed in the same cycle that a rising edge sets the flag, `edge_stat` ends up 1.
- R10: A pulse that is sampled low at a single clock edge is still detected, and it gives `low_cnt` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Low-power timer clock (about 131 kHz) |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 1 | Asynchronous bus line, idles high |
| bus_mode | input | 1 | Enables measurement |
| rise_ie | input | 1 | Rising-edge interrupt enable |
| stat_clr | input | 1 | Write-1-to-clear strobe for the status flag |
| low_cnt | output | 16 | Held low-time count |
| irq | output | 1 | Interrupt request |
| edge_stat | output | 1 | Sticky rising-edge status flag |

## Verification
The hardest case to reach is a clear strobe that lands in exactly the cycle where the rising edge is recorded. That cycle is the third clock edge after the bus goes high, because of the synchroniser and the edge register. The bench derives that cycle from the moment it releases the bus and pulses `stat_clr` there. Saturation needs a low period longer than 65535 cycles, so one directed stuck-low pulse is run. Random pulse widths are mixed with random enable settings to cover the measurement and the gating.

// File: rtl/lowtime_timer.sv
module lowtime_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bus_in,
  input  logic         bus_mode,
  input  logic         rise_ie,
  input  logic         stat_clr,
  output logic [W-1:0] low_cnt,
  output logic         irq,
  output logic         edge_stat
);
  localparam logic [W-1:0] CMAX = {W{1'b1}};

  logic s1, s2, s3, run;
  logic fall, rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {s1, s2, s3} <= 3'b111;
    else        {s1, s2, s3} <= {bus_in, s1, s2};

  assign fall = bus_mode & s3 & ~s2;
  assign rise = bus_mode & ~s3 & s2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      run     <= 1'b0;
      low_cnt <= '0;
    end else if (!bus_mode) begin
      run     <= 1'b0;
    end else if (fall) begin
      run     <= 1'b1;
      low_cnt <= '0;
    end else if (rise) begin
      run     <= 1'b0;
    end else if (run && low_cnt != CMAX) begin
      low_cnt <= low_cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                edge_stat <= 1'b0;
    else if (rise && rise_ie)  edge_stat <= 1'b1;
    else if (stat_clr)         edge_stat <= 1'b0;

  assign irq = edge_stat;

  // R2
  fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> (low_cnt == '0 && run));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !fall) |=> $stable(low_cnt));
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !fall && low_cnt == CMAX) |=> low_cnt == CMAX);
  // R5
  mode_off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_mode |=> (!run && $stable(low_cnt)));
  // R6
  rise_sets_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && rise_ie) |=> edge_stat);
  // R8
  clear_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr && !(rise && rise_ie)) |=> !edge_stat);
endmodule

// File: tb/sim_lowtime_timer.sv
module sim_lowtime_timer;
  logic clk = 0, rst_n = 0;
  logic bus_in = 1, bus_mode = 0, rise_ie = 0, stat_clr = 0;
  logic [15:0] low_cnt;
  logic irq, edge_stat;
  int tests = 0, fails = 0;
  int cyc = 0;
  bit done = 0;

  lowtime_timer u0 (.clk(clk), .rst_n(rst_n), .bus_in(bus_in), .bus_mode(bus_mode),
    .rise_ie(rise_ie), .stat_clr(stat_clr), .low_cnt(low_cnt), .irq(irq), .edge_stat(edge_stat));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [15:0] exp_cnt(int n);
    return (n - 1 > 65535) ? 16'hFFFF : 16'(n - 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic ncyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // drive bus low for n edges, then high; clr_at_set pulses stat_clr in the flag-set cycle
  task automatic pulse(int n, bit clr_at_set);
    bus_in = 0;
    ncyc(n);
    bus_in = 1;
    ncyc(2);
    if (clr_at_set) stat_clr = 1;
    ncyc(1);
    stat_clr = 0;
    ncyc(2);
  endtask

  task automatic clear_flag();
    stat_clr = 1; ncyc(1); stat_clr = 0; ncyc(1);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cyc > 190000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=<190000", cyc);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] prev;
    void'($urandom(32'h5eed));
    ncyc(3);
    chk("R1 cnt", low_cnt, 0);
    chk("R1 stat", edge_stat, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    ncyc(2);
    bus_mode = 1;
    rise_ie = 1;
    ncyc(2);

    pulse(1, 0);
    chk("R10 one-edge pulse", low_cnt, 0);
    chk("R6 stat", edge_stat, 1);
    chk("R6 irq", irq, 1);
    clear_flag();
    chk("R8 cleared", edge_stat, 0);
    chk("R8 irq cleared", irq, 0);

    pulse(40, 0);
    chk("R2 n=40", low_cnt, exp_cnt(40));
    ncyc(20);
    chk("R3 hold", low_cnt, exp_cnt(40));
    clear_flag();

    pulse(25, 1);
    chk("R9 set wins", edge_stat, 1);
    chk("R2 n=25", low_cnt, exp_cnt(25));
    clear_flag();

    rise_ie = 0;
    pulse(17, 0);
    chk("R7 no stat", edge_stat, 0);
    chk("R7 measured", low_cnt, exp_cnt(17));
    rise_ie = 1;

    for (int i = 0; i < 40; i++) begin
      int n;
      bit m, ie;
      n  = 1 + int'($urandom_range(0, 300));
      m  = ($urandom_range(0, 3) != 0);
      ie = $urandom_range(0, 1);
      bus_mode = m;
      rise_ie = ie;
      prev = low_cnt;
      ncyc(2);
      pulse(n, 0);
      if (m) begin
        chk("R2 random", low_cnt, exp_cnt(n));
        chk(ie ? "R6 random" : "R7 random", edge_stat, ie);
      end else begin
        chk("R5 ignored cnt", low_cnt, prev);
        chk("R5 ignored stat", edge_stat, 0);
      end
      bus_mode = 1;
      ncyc(2);
      clear_flag();
    end

    bus_mode = 1;
    rise_ie = 1;
    ncyc(2);
    pulse(70000, 0);
    chk("R4 saturate", low_cnt, exp_cnt(70000));
    ncyc(5);
    chk("R3 hold sat", low_cnt, 65535);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule